// File: doc/BRIEF.md
# Vectored Prioritized Interrupt Controller

This block collects 64 level-sensitive interrupt sources and turns them into two request lines for a processor: a normal request and a fast request. Software reaches it through a plain 32-bit register bus (byte address, write strobe, write data, combinational read data). Each source has an enable bit, a path-select bit and a 4-bit priority. A software force bit can also assert each source.

A source is active when its input or its force bit is 1. It is pending on the fast path when it is active, enabled and its path bit is 1. It is pending on the normal path when it is active, enabled and its path bit is 0. Pending is purely level-based, with nothing latched. Normal pending sources pass a priority threshold. Among those that pass, an arbiter picks the highest priority and reports the winner in a vector/status word. The fast path reports its highest-numbered pending source.

Enables can be changed in bulk through two enable words. A single enable bit can also be set or cleared by writing a source number to a dedicated port, so no read-modify-write is needed.

Top module: `vpic_top`

## Requirements
- R1: After reset the threshold register (0x04, bits [4:0]) reads 0x1F. Control (0x00), enable words (0x10 high = sources 63..32, 0x14 low = sources 31..0), path words and all priority words read 0. Both request outputs are 0, and both vector words read 0xFFFFFFFF.
- R2: Writing n < 64 to the set-number port 0x08 sets enable bit n. Writing n to the clear-number port 0x0C clears enable bit n. No other enable bit changes. Values of 64 or above change nothing. Both ports read 0.
- R3: The enable words at 0x10 (high) and 0x14 (low) are written and read back directly, bit k of a word standing for source 32*word+k.
- R4: Path words sit at 0x18 (high) and 0x1C (low). A 1 sends the source to the fast path and a 0 sends it to the normal path. A source is never pending on both paths.
- R5: Source n's priority is the nibble at bits [4*(n%8)+3:4*(n%8)] of the word at 0x20 + 4*(7 - n/8). Sources 56..63 are at 0x20 and sources 0..7 are at 0x3C, and these words read back as written.
- R6: Raw inputs read at 0x48 (high) and 0x4C (low). Force words at 0x50 (high) and 0x54 (low) make a source active without showing up in the raw words.
- R7: Normal pending reads at 0x58/0x5C and fast pending at 0x60/0x64. Each bit follows active AND enable AND path-select with no latching.
- R8: The normal request output is 1 exactly when some normal pending source has a priority strictly above the threshold. A threshold above 0xF blocks all normal sources.
- R9: The normal vector word at 0x40 holds the winning source number in [31:16] and its priority in [15:0]. The winner is the highest priority above the threshold, with ties going to the highest source number. The word is 0xFFFFFFFF when no source passes.
- R10: The fast vector word at 0x44 holds the highest-numbered fast pending source in [31:16], with [15:0] zero, or 0xFFFFFFFF when none is pending. The fast request output is 1 exactly when any fast pending bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Byte address of the register access |
| bus_we | input | 1 | Write strobe, captured on the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| src_in | input | 64 | Level-sensitive source inputs, bit n = source n |
| nreq | output | 1 | Normal interrupt request |
| freq | output | 1 | Fast interrupt request |

## Verification
Every cycle, the assertions check the following:
- A number written to the set or clear port lands on exactly that enable bit, and an out-of-range number leaves the enable state unchanged.
- The normal request never rises while the threshold is above 0xF.
- The normal vector always agrees with the normal request, and its priority always sits above the threshold.
- The fast vector always agrees with the fast request.

Only the bench scenarios can show the following:
- The priority nibble layout in reversed word order.
- Tie-breaking toward the higher source number.
- The force path staying out of the raw words.
- Pending bits dropping as soon as an input falls.

// File: rtl/vpic_pkg.sv
package vpic_pkg;
   localparam logic [7:0] OFS_CTRL   = 8'h00;
   localparam logic [7:0] OFS_THRESH = 8'h04;
   localparam logic [7:0] OFS_ENSET  = 8'h08;
   localparam logic [7:0] OFS_ENCLR  = 8'h0C;
   localparam logic [7:0] OFS_ENH    = 8'h10;
   localparam logic [7:0] OFS_ENL    = 8'h14;
   localparam logic [7:0] OFS_PATHH  = 8'h18;
   localparam logic [7:0] OFS_PATHL  = 8'h1C;
   localparam logic [7:0] OFS_PRIO0  = 8'h20;
   localparam logic [7:0] OFS_NVEC   = 8'h40;
   localparam logic [7:0] OFS_FVEC   = 8'h44;
   localparam logic [7:0] OFS_RAWH   = 8'h48;
   localparam logic [7:0] OFS_RAWL   = 8'h4C;
   localparam logic [7:0] OFS_FRCH   = 8'h50;
   localparam logic [7:0] OFS_FRCL   = 8'h54;
   localparam logic [7:0] OFS_NPNDH  = 8'h58;
   localparam logic [7:0] OFS_NPNDL  = 8'h5C;
   localparam logic [7:0] OFS_FPNDH  = 8'h60;
   localparam logic [7:0] OFS_FPNDL  = 8'h64;
   localparam int THRESH_W = 5;
endpackage

// File: rtl/vpic_regs.sv
module vpic_regs
   import vpic_pkg::*;
#(
   parameter int NSRC = 64,
   parameter int DW   = 32,
   parameter int PW   = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                we,
   input  logic [7:0]          addr,
   input  logic [DW-1:0]       wdata,
   output logic [DW-1:0]       ctrl_q,
   output logic [THRESH_W-1:0] thresh_q,
   output logic [NSRC-1:0]     en_q,
   output logic [NSRC-1:0]     path_q,
   output logic [NSRC-1:0]     frc_q,
   output logic [NSRC*PW-1:0]  prio_q
);
   localparam int NUM_W   = $clog2(NSRC);
   localparam int PER_REG = DW / PW;
   localparam int NGRP    = NSRC / PER_REG;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q   <= '0;
         thresh_q <= '1;
         en_q     <= '0;
         path_q   <= '0;
         frc_q    <= '0;
         prio_q   <= '0;
      end else if (we) begin
         case (addr)
            OFS_CTRL:   ctrl_q   <= wdata;
            OFS_THRESH: thresh_q <= wdata[THRESH_W-1:0];
            OFS_ENSET:  if (wdata < DW'(NSRC)) en_q[wdata[NUM_W-1:0]] <= 1'b1;
            OFS_ENCLR:  if (wdata < DW'(NSRC)) en_q[wdata[NUM_W-1:0]] <= 1'b0;
            OFS_ENH:    en_q[NSRC-1:DW]   <= wdata;
            OFS_ENL:    en_q[DW-1:0]      <= wdata;
            OFS_PATHH:  path_q[NSRC-1:DW] <= wdata;
            OFS_PATHL:  path_q[DW-1:0]    <= wdata;
            OFS_FRCH:   frc_q[NSRC-1:DW]  <= wdata;
            OFS_FRCL:   frc_q[DW-1:0]     <= wdata;
            default: ;
         endcase
         // priority words are laid out in reversed group order
         for (int k = 0; k < NGRP; k++) begin
            if (addr == OFS_PRIO0 + 8'(4*k))
               prio_q[(NGRP-1-k)*DW +: DW] <= wdata;
         end
      end
   end
endmodule

// File: rtl/vpic_norm_arb.sv
module vpic_norm_arb
   import vpic_pkg::*;
#(
   parameter int NSRC     = 64,
   parameter int PW       = 4,
   parameter bit TIE_HIGH = 1'b1
) (
   input  logic [NSRC-1:0]         pend,
   input  logic [NSRC*PW-1:0]      prio,
   input  logic [THRESH_W-1:0]     thresh,
   output logic                    vld,
   output logic [$clog2(NSRC)-1:0] num,
   output logic [PW-1:0]           best
);
   localparam int NUM_W = $clog2(NSRC);
   logic [NSRC-1:0] elig;
   logic [NSRC-1:0] beats;

   always_comb begin
      for (int i = 0; i < NSRC; i++)
         elig[i] = pend[i] && (THRESH_W'(prio[i*PW +: PW]) > thresh);
   end

   // comparator variant decides which end wins a tie
   generate
      if (TIE_HIGH) begin : g_tie_high
         always_comb
            for (int i = 0; i < NSRC; i++) beats[i] = 1'b1;
      end else begin : g_tie_low
         always_comb
            for (int i = 0; i < NSRC; i++) beats[i] = 1'b0;
      end
   endgenerate

   always_comb begin
      vld  = 1'b0;
      num  = '0;
      best = '0;
      for (int i = 0; i < NSRC; i++) begin
         if (elig[i] && (!vld || prio[i*PW +: PW] > best ||
                         (beats[i] && prio[i*PW +: PW] == best))) begin
            vld  = 1'b1;
            num  = NUM_W'(i);
            best = prio[i*PW +: PW];
         end
      end
   end
endmodule

// File: rtl/vpic_fast_sel.sv
module vpic_fast_sel #(
   parameter int NSRC = 64
) (
   input  logic [NSRC-1:0]         pend,
   output logic                    vld,
   output logic [$clog2(NSRC)-1:0] num
);
   localparam int NUM_W = $clog2(NSRC);
   always_comb begin
      vld = 1'b0;
      num = '0;
      for (int i = 0; i < NSRC; i++) begin
         if (pend[i]) begin
            vld = 1'b1;
            num = NUM_W'(i);
         end
      end
   end
endmodule

// File: rtl/vpic_top.sv
module vpic_top
   import vpic_pkg::*;
#(
   parameter int NSRC = 64,
   parameter int DW   = 32,
   parameter int PW   = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [7:0]      bus_addr,
   input  logic            bus_we,
   input  logic [DW-1:0]   bus_wdata,
   output logic [DW-1:0]   bus_rdata,
   input  logic [NSRC-1:0] src_in,
   output logic            nreq,
   output logic            freq
);
   localparam int NUM_W   = $clog2(NSRC);
   localparam int HALF    = DW / 2;
   localparam int PER_REG = DW / PW;
   localparam int NGRP    = NSRC / PER_REG;

   generate
      if (NSRC != 2*DW) begin : g_bad_nsrc
         $error("vpic_top: NSRC must equal two data words");
      end
      if (PER_REG * PW != DW || NUM_W > HALF) begin : g_bad_pw
         $error("vpic_top: priority width must divide the data word");
      end
   endgenerate

   logic [DW-1:0]       ctrl_q;
   logic [THRESH_W-1:0] mask_q;
   logic [NSRC-1:0]     en_q, path_q, frc_q;
   logic [NSRC*PW-1:0]  prio_q;
   logic [NSRC-1:0]     act, npend, fpend;
   logic                n_vld, f_vld;
   logic [NUM_W-1:0]    n_num, f_num;
   logic [PW-1:0]       n_pri;
   logic [DW-1:0]       nvec, fvec;

   vpic_regs #(.NSRC(NSRC), .DW(DW), .PW(PW)) u_regs (
      .clk(clk), .rst_n(rst_n), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
      .ctrl_q(ctrl_q), .thresh_q(mask_q), .en_q(en_q), .path_q(path_q),
      .frc_q(frc_q), .prio_q(prio_q)
   );

   assign act   = src_in | frc_q;
   assign npend = act & en_q & ~path_q;
   assign fpend = act & en_q & path_q;

   vpic_norm_arb #(.NSRC(NSRC), .PW(PW), .TIE_HIGH(1'b1)) u_narb (
      .pend(npend), .prio(prio_q), .thresh(mask_q),
      .vld(n_vld), .num(n_num), .best(n_pri)
   );

   vpic_fast_sel #(.NSRC(NSRC)) u_fsel (
      .pend(fpend), .vld(f_vld), .num(f_num)
   );

   assign nreq = n_vld;
   assign freq = f_vld;
   assign nvec = n_vld ? {HALF'(n_num), HALF'(n_pri)} : '1;
   assign fvec = f_vld ? {HALF'(f_num), HALF'(0)} : '1;

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         OFS_CTRL:   bus_rdata = ctrl_q;
         OFS_THRESH: bus_rdata = DW'(mask_q);
         OFS_ENH:    bus_rdata = en_q[NSRC-1:DW];
         OFS_ENL:    bus_rdata = en_q[DW-1:0];
         OFS_PATHH:  bus_rdata = path_q[NSRC-1:DW];
         OFS_PATHL:  bus_rdata = path_q[DW-1:0];
         OFS_NVEC:   bus_rdata = nvec;
         OFS_FVEC:   bus_rdata = fvec;
         OFS_RAWH:   bus_rdata = src_in[NSRC-1:DW];
         OFS_RAWL:   bus_rdata = src_in[DW-1:0];
         OFS_FRCH:   bus_rdata = frc_q[NSRC-1:DW];
         OFS_FRCL:   bus_rdata = frc_q[DW-1:0];
         OFS_NPNDH:  bus_rdata = npend[NSRC-1:DW];
         OFS_NPNDL:  bus_rdata = npend[DW-1:0];
         OFS_FPNDH:  bus_rdata = fpend[NSRC-1:DW];
         OFS_FPNDL:  bus_rdata = fpend[DW-1:0];
         default: begin
            for (int k = 0; k < NGRP; k++)
               if (bus_addr == OFS_PRIO0 + 8'(4*k))
                  bus_rdata = prio_q[(NGRP-1-k)*DW +: DW];
         end
      endcase
   end
endmodule

// File: rtl/vpic_chk.sv
module vpic_chk
   import vpic_pkg::*;
#(
   parameter int NSRC = 64,
   parameter int DW   = 32
) (
   input logic                clk,
   input logic                rst_n,
   input logic                bus_we,
   input logic [7:0]          bus_addr,
   input logic [DW-1:0]       bus_wdata,
   input logic [NSRC-1:0]     en_q,
   input logic [THRESH_W-1:0] mask_q,
   input logic                nreq,
   input logic                freq,
   input logic [DW-1:0]       nvec,
   input logic [DW-1:0]       fvec
);
   localparam int NUM_W = $clog2(NSRC);
   localparam int HALF  = DW / 2;

   // R2: a set-number write lands on the named enable bit
   assert_enset_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == OFS_ENSET && bus_wdata < DW'(NSRC))
      |=> en_q[$past(bus_wdata[NUM_W-1:0])]);

   // R2: a clear-number write drops the named enable bit
   assert_enclr_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == OFS_ENCLR && bus_wdata < DW'(NSRC))
      |=> !en_q[$past(bus_wdata[NUM_W-1:0])]);

   // R2: out-of-range numbers leave every enable bit alone
   assert_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && (bus_addr == OFS_ENSET || bus_addr == OFS_ENCLR) &&
       bus_wdata >= DW'(NSRC)) |=> $stable(en_q));

   // R8: threshold above 0xF blocks the normal request
   assert_block_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_q > THRESH_W'(15)) |-> !nreq);

   // R9: the vector word agrees with the request and clears the threshold
   assert_nvec_R9: assert property (@(posedge clk) disable iff (!rst_n)
      nreq |-> (nvec != '1 && nvec[HALF-1:0] > HALF'(mask_q)));

   assert_nidle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !nreq |-> nvec == '1);

   // R10: fast vector agrees with the fast request
   assert_fvec_R10: assert property (@(posedge clk) disable iff (!rst_n)
      freq ? (fvec[HALF-1:0] == '0 && fvec[DW-1:HALF] < HALF'(NSRC)) : fvec == '1);
endmodule

bind vpic_top vpic_chk #(.NSRC(NSRC), .DW(DW)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
   .bus_wdata(bus_wdata), .en_q(en_q), .mask_q(mask_q), .nreq(nreq),
   .freq(freq), .nvec(nvec), .fvec(fvec)
);

// File: tb/test_vpic_top.sv
module test_vpic_top;
   timeunit 1ns;
   timeprecision 1ns;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic        bus_we = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [63:0] src_in = '0;
   logic        nreq, freq;

   int compared = 0;
   int mismatched = 0;
   bit done = 1'b0;

   int          q_kind[$];
   logic [31:0] q_exp[$];
   string       q_tag[$];

   vpic_top i_vpic_top (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_in(src_in),
      .nreq(nreq), .freq(freq)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   // monitor: pops one expected item per falling edge and compares
   always @(negedge clk) begin
      if (q_kind.size() > 0) begin
         int          k;
         logic [31:0] e, a;
         string       t;
         k = q_kind.pop_front();
         e = q_exp.pop_front();
         t = q_tag.pop_front();
         a = (k == 0) ? bus_rdata : (k == 1) ? {31'b0, nreq} : {31'b0, freq};
         compared++;
         if (a !== e) begin
            mismatched++;
            $display("FAIL %s kind=%0d actual=%h expected=%h", t, k, a, e);
         end
      end
   end

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(posedge clk); #1;
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk); #1;
      bus_we = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, input logic [31:0] e, input string t);
      @(posedge clk); #1;
      bus_addr = a;
      q_kind.push_back(0); q_exp.push_back(e); q_tag.push_back(t);
      @(negedge clk); #1;
   endtask

   task automatic pin(input int k, input logic e, input string t);
      @(posedge clk); #1;
      q_kind.push_back(k); q_exp.push_back({31'b0, e}); q_tag.push_back(t);
      @(negedge clk); #1;
   endtask

   task automatic drive_src(input logic [63:0] v);
      @(posedge clk); #1;
      src_in = v;
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         mismatched++;
         $display("FAIL watchdog expired actual=hung expected=done");
         summary();
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1 reset state
      rd(8'h04, 32'h1F, "R1 threshold");
      rd(8'h10, 32'h0, "R1 enable high");
      rd(8'h1C, 32'h0, "R1 path low");
      rd(8'h3C, 32'h0, "R1 priority");
      rd(8'h40, 32'hFFFF_FFFF, "R1 nvec");
      rd(8'h44, 32'hFFFF_FFFF, "R1 fvec");
      pin(1, 1'b0, "R1 nreq");
      pin(2, 1'b0, "R1 freq");

      // R2 number ports
      wr(8'h08, 32'd5);
      rd(8'h14, 32'h0000_0020, "R2 set 5");
      wr(8'h08, 32'd40);
      rd(8'h10, 32'h0000_0100, "R2 set 40");
      wr(8'h08, 32'd64);
      rd(8'h14, 32'h0000_0020, "R2 ignore 64 low");
      rd(8'h10, 32'h0000_0100, "R2 ignore 64 high");
      rd(8'h08, 32'h0, "R2 set port reads 0");
      wr(8'h0C, 32'd5);
      rd(8'h14, 32'h0, "R2 clear 5");

      // R3 direct enable words: sources 4..7, 32, 63
      wr(8'h14, 32'h0000_00F0);
      wr(8'h10, 32'h8000_0001);
      rd(8'h14, 32'h0000_00F0, "R3 enable low");
      rd(8'h10, 32'h8000_0001, "R3 enable high");

      // R5 priority layout: src5 -> 3 at 0x3C, src63 -> 9 at 0x20
      wr(8'h3C, 32'h0030_0000);
      wr(8'h20, 32'h9000_0000);
      rd(8'h20, 32'h9000_0000, "R5 word 0x20");
      rd(8'h3C, 32'h0030_0000, "R5 word 0x3C");

      // R6/R7 raw and pending, threshold still blocking
      drive_src(64'h20);
      rd(8'h4C, 32'h0000_0020, "R6 raw low");
      rd(8'h5C, 32'h0000_0020, "R7 normal pending");
      pin(1, 1'b0, "R8 fully masked");
      rd(8'h40, 32'hFFFF_FFFF, "R9 nothing passes");

      // R8 threshold
      wr(8'h04, 32'd2);
      pin(1, 1'b1, "R8 prio 3 over 2");
      rd(8'h40, 32'h0005_0003, "R9 single winner");
      wr(8'h04, 32'd3);
      pin(1, 1'b0, "R8 equal blocked");
      wr(8'h04, 32'h10);
      pin(1, 1'b0, "R8 above 0xF blocks");
      wr(8'h04, 32'd0);

      // R9 tie to highest number; prio 0 never passes
      wr(8'h3C, 32'h0330_0000);
      drive_src(64'h70);
      rd(8'h40, 32'h0006_0003, "R9 tie high number");
      wr(8'h50, 32'h8000_0000);
      rd(8'h40, 32'h003F_0009, "R9 forced 63 wins");
      rd(8'h48, 32'h0, "R6 force not in raw");
      rd(8'h58, 32'h8000_0000, "R7 normal pending high");

      // R4/R10 fast path
      wr(8'h1C, 32'h0000_0040);
      rd(8'h64, 32'h0000_0040, "R4 fast pending low");
      rd(8'h5C, 32'h0000_0030, "R4 normal pending low");
      pin(2, 1'b1, "R10 freq");
      rd(8'h44, 32'h0006_0000, "R10 fvec 6");
      wr(8'h18, 32'h0000_0001);
      wr(8'h50, 32'h8000_0001);
      rd(8'h60, 32'h0000_0001, "R7 fast pending high");
      rd(8'h44, 32'h0020_0000, "R10 fvec 32");
      rd(8'h40, 32'h003F_0009, "R9 unaffected by fast");

      // R7 level behaviour
      drive_src(64'h0);
      rd(8'h64, 32'h0, "R7 fast drops");
      wr(8'h50, 32'h0);
      pin(2, 1'b0, "R10 freq low");
      rd(8'h44, 32'hFFFF_FFFF, "R10 fvec idle");
      pin(1, 1'b0, "R8 nreq low");

      // R2 clear 63, out-of-range clear ignored
      wr(8'h0C, 32'd63);
      rd(8'h10, 32'h0000_0001, "R2 clear 63");
      wr(8'h0C, 32'd70);
      rd(8'h10, 32'h0000_0001, "R2 ignore 70");
      rd(8'h0C, 32'h0, "R2 clear port reads 0");

      repeat (2) @(posedge clk);
      done = 1'b1;
      summary();
   end
endmodule